// File: doc/BRIEF.md
# Accumulating Register Adder

This block holds a running total in an accumulator register and adds operand words into it one at a time. An operand register captures a word from a memory data bus. A combinational ripple adder, one full-adder cell per bit, continuously forms the sum of the accumulator and the operand. Three independent control strobes act on the registers at the rising clock edge. Clear zeroes the accumulator. Load copies the bus word into the operand register. Transfer writes the adder sum back into the accumulator.

A series of operands is summed by clearing once and then repeating load followed by transfer. The running total and the carry out of the top adder bit are the outputs. For each edge, a small decoder reduces the accumulator controls to one of three named operations: HOLD (keep the value), ZERO (clear) or SUM (write the adder result). Clear wins over transfer. Load acts on the operand register independently of the other two controls.

Top module: `acc_ripple_adder`

## Requirements
- R1: A synchronous active-high reset sets both the accumulator and the operand register to 0. After reset, acc_o is 0, carry_o is 0, and a transfer with no prior load leaves acc_o at 0.
- R2: When clear_i is high at a rising edge, every bit of the accumulator is 0 after that edge.
- R3: When load_i is high at a rising edge, the operand register takes mem_data_i at that edge.
- R4: When xfer_i is high and clear_i is low at a rising edge, the accumulator becomes (accumulator + operand) mod 2^W at that edge.
- R5: carry_o is combinational. It is 1 exactly when the accumulator value plus the operand value, both unsigned, is 2^W or more.
- R6: When clear_i and xfer_i are both high at the same edge, the accumulator becomes 0.
- R7: When load_i and xfer_i are both high at the same edge, the sum is formed from the operand value held before that edge. The operand register takes the new bus word.
- R8: When clear_i and xfer_i are both low, the accumulator keeps its value. When load_i is low, the operand register keeps its value.
- R9: With W=4, starting from 0: loading 1001 and transferring gives acc_o=1001. Loading 0101 and transferring then gives acc_o=1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Zero the accumulator at the edge |
| load_i | input | 1 | Capture mem_data_i into the operand register |
| xfer_i | input | 1 | Write the adder sum into the accumulator |
| mem_data_i | input | W | Operand word from the memory data bus |
| acc_o | output | W | Accumulator contents |
| carry_o | output | 1 | Carry out of the most significant adder bit |

## Verification
Two pairs of actions can share one edge. Clear can arrive with transfer, and both act on the accumulator. Load can arrive with transfer, in which case the new operand is written while the old one is still being summed. Random stimulus raises each strobe independently, so both collisions occur many times, and directed cases force each one on known values. A bench model decides each collision from R6 and R7: clear wins, and the sum uses the operand held before the edge. The accumulator and carry are then compared with the model in the half cycle after the edge.

// File: rtl/acr_pkg.sv
package acr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ZERO = 2'd1,
        OP_SUM  = 2'd2
    } acc_op_t;
endpackage

// File: rtl/acr_full_adder.sv
module acr_full_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half;
    always_comb begin
        half = a_i ^ b_i;
        s_o  = half ^ c_i;
        c_o  = (a_i & b_i) | (c_i & half);
    end
endmodule

// File: rtl/acr_ripple.sv
module acr_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] chain;
    assign chain[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_cell
        acr_full_adder u_fa (
            .a_i (a_i[k]),
            .b_i (b_i[k]),
            .c_i (chain[k]),
            .s_o (sum_o[k]),
            .c_o (chain[k+1])
        );
    end

    assign cout_o = chain[W];
endmodule

// File: rtl/acr_op_decode.sv
module acr_op_decode
    import acr_pkg::*;
(
    input  logic    clear_i,
    input  logic    xfer_i,
    output acc_op_t op_o
);
    always_comb begin
        unique case ({clear_i, xfer_i})
            2'b00:   op_o = OP_HOLD;
            2'b01:   op_o = OP_SUM;
            2'b10:   op_o = OP_ZERO;
            2'b11:   op_o = OP_ZERO;
            default: op_o = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/acc_ripple_adder.sv
module acc_ripple_adder
    import acr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic         xfer_i,
    input  logic [W-1:0] mem_data_i,
    output logic [W-1:0] acc_o,
    output logic         carry_o
);
    localparam logic [W-1:0] ZERO_W = '0;

    logic [W-1:0] acc_q;
    logic [W-1:0] opnd_q;
    logic [W-1:0] sum_w;
    logic         cout_w;
    acc_op_t      op_w;

    acr_op_decode u_dec (
        .clear_i (clear_i),
        .xfer_i  (xfer_i),
        .op_o    (op_w)
    );

    acr_ripple #(.W(W)) u_add (
        .a_i    (acc_q),
        .b_i    (opnd_q),
        .sum_o  (sum_w),
        .cout_o (cout_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= ZERO_W;
        end else begin
            unique case (op_w)
                OP_HOLD: acc_q <= acc_q;
                OP_ZERO: acc_q <= ZERO_W;
                OP_SUM:  acc_q <= sum_w;
                default: acc_q <= acc_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            opnd_q <= ZERO_W;
        else if (load_i)
            opnd_q <= mem_data_i;
    end

    always_comb begin
        acc_o   = acc_q;
        carry_o = cout_w;
    end
endmodule

// File: rtl/acc_ripple_adder_chk.sv
module acc_ripple_adder_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         clear_i,
    input logic         load_i,
    input logic         xfer_i,
    input logic [W-1:0] mem_data_i,
    input logic [W-1:0] acc_o,
    input logic         carry_o,
    input logic [W-1:0] opnd
);
    logic [W:0] wide_sum;
    assign wide_sum = {1'b0, acc_o} + {1'b0, opnd};

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (acc_o == '0 && opnd == '0));

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> acc_o == '0);

    // R3
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> opnd == $past(mem_data_i));

    // R4
    xfer_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && !clear_i) |=> acc_o == $past(wide_sum[W-1:0]));

    // R5
    carry_flag_chk: assert property (@(posedge clk) disable iff (rst)
        carry_o == wide_sum[W]);

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && !xfer_i) |=> $stable(acc_o));

    // R8
    opnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(opnd));
endmodule

bind acc_ripple_adder acc_ripple_adder_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (clear_i),
    .load_i     (load_i),
    .xfer_i     (xfer_i),
    .mem_data_i (mem_data_i),
    .acc_o      (acc_o),
    .carry_o    (carry_o),
    .opnd       (opnd_q)
);

// File: tb/sim_acc_ripple_adder.sv
module sim_acc_ripple_adder;
    localparam int W = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clear_i = 1'b0;
    logic         load_i = 1'b0;
    logic         xfer_i = 1'b0;
    logic [W-1:0] mem_data_i = '0;
    logic [W-1:0] acc_o;
    logic         carry_o;

    int checks = 0;
    int errors = 0;
    int m_acc = 0;
    int m_opnd = 0;

    always #4 clk = ~clk;

    acc_ripple_adder #(.W(W)) u0 (
        .clk(clk), .rst(rst), .clear_i(clear_i), .load_i(load_i),
        .xfer_i(xfer_i), .mem_data_i(mem_data_i), .acc_o(acc_o), .carry_o(carry_o)
    );

    function automatic int next_acc(int a, int b, bit c, bit x);
        if (c) return 0;
        if (x) return (a + b) & MASK;
        return a;
    endfunction

    function automatic bit exp_carry(int a, int b);
        return ((a + b) >> W) != 0;
    endfunction

    task automatic check(string tag);
        bit ec;
        ec = exp_carry(m_acc, m_opnd);
        checks++;
        if (int'(acc_o) != m_acc) begin
            errors++;
            $display("FAIL %s acc_o actual=%0d expected=%0d", tag, acc_o, m_acc);
        end
        checks++;
        if (carry_o != ec) begin
            errors++;
            $display("FAIL %s carry_o actual=%0d expected=%0d", tag, carry_o, ec);
        end
    endtask

    // Called at a falling edge; applies one edge and checks at the next falling edge.
    task automatic cyc(bit c, bit l, bit x, int d, string tag);
        int na;
        clear_i = c; load_i = l; xfer_i = x; mem_data_i = d[W-1:0];
        @(posedge clk);
        na = next_acc(m_acc, m_opnd, c, x);
        if (l) m_opnd = d & MASK;
        m_acc = na;
        @(negedge clk);
        clear_i = 0; load_i = 0; xfer_i = 0;
        check(tag);
    endtask

    initial begin
        #(8 * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1");
        cyc(0, 0, 1, 0, "R1");
        // R9 worked example
        cyc(1, 0, 0, 0, "R2");
        cyc(0, 1, 0, 9, "R3");
        cyc(0, 0, 1, 0, "R9");
        cyc(0, 1, 0, 5, "R3");
        cyc(0, 0, 1, 0, "R9");
        checks++;
        if (acc_o != 4'b1110) begin
            errors++;
            $display("FAIL R9 acc_o actual=%b expected=1110", acc_o);
        end
        // R5 and R4 wrap: 1110 + 0010 = 0000 with carry
        cyc(0, 1, 0, 2, "R5");
        checks++;
        if (carry_o != 1'b1) begin
            errors++;
            $display("FAIL R5 carry_o actual=%0d expected=1", carry_o);
        end
        cyc(0, 0, 1, 0, "R4");
        // R8 hold with changing bus and no strobes
        cyc(0, 0, 0, 15, "R8");
        cyc(0, 0, 0, 7, "R8");
        // R6 clear beats transfer
        cyc(0, 0, 1, 0, "R4");
        cyc(1, 0, 1, 0, "R6");
        // R7 load with transfer uses old operand
        cyc(0, 1, 0, 3, "R3");
        cyc(0, 1, 1, 12, "R7");
        cyc(0, 0, 1, 0, "R7");
        cyc(1, 1, 1, 6, "R6");
        for (int i = 0; i < 400; i++) begin
            int r;
            bit c, l, x;
            string tag;
            r = $urandom;
            c = (r[3:0] == 0);
            l = r[4];
            x = r[5] | r[6];
            if (c && x) tag = "R6";
            else if (l && x) tag = "R7";
            else if (c) tag = "R2";
            else if (x) tag = "R4";
            else if (l) tag = "R3";
            else tag = "R8";
            cyc(c, l, x, r[15:8], tag);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule